// File: doc/BRIEF.md
# Largest-Queue Crossbar Scheduler

This block is the central arbiter of a four-port packet switch. Each input port keeps one queue per destination, so there are sixteen queues in all. Queue (i, j) holds packets from input i that are bound for output j. Each cycle the scheduler looks at every output buffer that has room and is not already filling. For each such output it picks one of the four queues aimed at that output: the fullest one wins. When several queues share the top count, the one met first in a scan that begins at a rotating start index wins.

A grant starts both ends of an eight-word packet move at the same time. The chosen queue gets a one-cycle read-start pulse. The output buffer gets a one-cycle write-start pulse and a held multiplexer select naming the source input. The output then stays locked until the move is over. The start index steps by one after every cycle that produced a grant, which spreads ties across the inputs over time.

Top module: `xbar_sched`

## Requirements
- R1: While reset is high, every read-start, write-start, select and busy output is zero, and the start index is zero.
- R2: An output is granted only in the cycle after one in which its room input was high and its busy output was low.
- R3: Among the queues aimed at an eligible output, the grant goes to the queue with the largest occupancy.
- R4: When queues tie on the largest occupancy, the grant goes to the first of them in the scan order start, start+1, … wrapping modulo the port count.
- R5: A queue with zero occupancy is never granted. An eligible output whose queues are all empty gets no grant.
- R6: A grant shows as a one-cycle pulse on write-start bit j together with read-start bit i*N+j (N ports), where i is the chosen input. Both appear one cycle after the deciding inputs.
- R7: The select field of output j (bits j*IDX_W upward) takes the chosen input index in the pulse cycle. It holds that value until the next grant to j.
- R8: The busy output of j is high for exactly 8 cycles, starting with the write-start pulse cycle.
- R9: The start index advances by one, modulo N, after any cycle that issues at least one grant. It is unchanged otherwise.
- R10: At most one read-start pulse is active among the queues of any one output, and none is active for an output that is not pulsing write-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_occ_i | input | N*N*OCC_W | Occupancy of queue (i, j) at field i*N+j |
| ob_room_i | input | N | Output buffer j can accept a packet |
| rd_start_o | output | N*N | Read-start pulse to queue (i, j), bit i*N+j |
| wr_start_o | output | N | Write-start pulse to output buffer j |
| sel_o | output | N*IDX_W | Multiplexer select per output: source input index |
| busy_o | output | N | Output j is locked by a transfer in progress |

## Verification
A wrong start index does not show at once. It surfaces at the next grant where occupancies tie, as the wrong select value and the wrong read-start bit. The bench therefore sets up deliberate ties right after known grants. A wrong lock counter shows as a busy output of the wrong length, or as a grant that lands too early or too late on an output that has room all the time. This is caught within one transfer length. A faulty comparison in the picker shows up in the very next pulse cycle, as a select naming a smaller or empty queue. The cycle-by-cycle reference model compares every output bit on every clock, so each of these faults is reported in the first cycle it becomes visible.

// File: rtl/xbar_sched_pkg.sv
package xbar_sched_pkg;

    localparam int DEF_PORTS = 4;
    localparam int DEF_OCC_W = 4;
    localparam int DEF_XFER  = 8;

    // (a + b) mod n for 0 <= a, b < n
    function automatic int wrap_add(input int a, input int b, input int n);
        int s;
        s = a + b;
        if (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/xbar_sched_pick.sv
module xbar_sched_pick #(
    parameter int NPORTS = 4,
    parameter int OCC_W  = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NPORTS*OCC_W-1:0] occ_col,
    input  logic [IDX_W-1:0]        start,
    input  logic                    enable,
    output logic                    hit,
    output logic [IDX_W-1:0]        win
);
    // Scan from the start index; replace only on strictly greater count.
    always_comb begin
        logic [OCC_W-1:0] best;
        int idx;
        best = '0;
        hit  = 1'b0;
        win  = '0;
        for (int k = 0; k < NPORTS; k++) begin
            idx = xbar_sched_pkg::wrap_add(int'(start), k, NPORTS);
            if (enable && (occ_col[idx*OCC_W +: OCC_W] > best)) begin
                best = occ_col[idx*OCC_W +: OCC_W];
                win  = IDX_W'(idx);
                hit  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xbar_sched_lock.sv
module xbar_sched_lock #(
    parameter int XFER_LEN = 8,
    parameter int CNT_W    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CNT_W'(XFER_LEN);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/xbar_sched.sv
module xbar_sched #(
    parameter int NPORTS   = xbar_sched_pkg::DEF_PORTS,
    parameter int OCC_W    = xbar_sched_pkg::DEF_OCC_W,
    parameter int XFER_LEN = xbar_sched_pkg::DEF_XFER
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NPORTS*NPORTS*OCC_W-1:0]      q_occ_i,
    input  logic [NPORTS-1:0]                   ob_room_i,
    output logic [NPORTS*NPORTS-1:0]            rd_start_o,
    output logic [NPORTS-1:0]                   wr_start_o,
    output logic [NPORTS*$clog2(NPORTS)-1:0]    sel_o,
    output logic [NPORTS-1:0]                   busy_o
);
    localparam int IDX_W = $clog2(NPORTS);
    localparam int CNT_W = $clog2(XFER_LEN + 1);

    logic [IDX_W-1:0]  ptr_q;
    logic [NPORTS-1:0] hit_vec;

    for (genvar j = 0; j < NPORTS; j++) begin : g_out
        logic [NPORTS*OCC_W-1:0] col;
        logic                    hit;
        logic [IDX_W-1:0]        win;
        logic [NPORTS-1:0]       rd_q;
        logic                    wr_q;
        logic [IDX_W-1:0]        sel_q;

        for (genvar i = 0; i < NPORTS; i++) begin : g_col
            assign col[i*OCC_W +: OCC_W] = q_occ_i[(i*NPORTS+j)*OCC_W +: OCC_W];
            assign rd_start_o[i*NPORTS+j] = rd_q[i];
        end

        xbar_sched_pick #(.NPORTS(NPORTS), .OCC_W(OCC_W), .IDX_W(IDX_W)) u_pick (
            .occ_col (col),
            .start   (ptr_q),
            .enable  (ob_room_i[j] & ~busy_o[j]),
            .hit     (hit),
            .win     (win)
        );

        xbar_sched_lock #(.XFER_LEN(XFER_LEN), .CNT_W(CNT_W)) u_lock (
            .clk  (clk),
            .rst  (rst),
            .load (hit),
            .busy (busy_o[j])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                rd_q  <= '0;
                wr_q  <= 1'b0;
                sel_q <= '0;
            end else begin
                wr_q <= hit;
                for (int i = 0; i < NPORTS; i++)
                    rd_q[i] <= hit && (win == IDX_W'(i));
                if (hit)
                    sel_q <= win;
            end
        end

        assign hit_vec[j]                  = hit;
        assign wr_start_o[j]               = wr_q;
        assign sel_o[j*IDX_W +: IDX_W]     = sel_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (|hit_vec)
            ptr_q <= IDX_W'(xbar_sched_pkg::wrap_add(int'(ptr_q), 1, NPORTS));
    end
endmodule

// File: rtl/xbar_sched_chk.sv
module xbar_sched_chk #(
    parameter int NPORTS = 4,
    parameter int OCC_W  = 4,
    parameter int IDX_W  = 2
) (
    input logic                           clk,
    input logic                           rst,
    input logic [NPORTS*NPORTS*OCC_W-1:0] q_occ,
    input logic [NPORTS-1:0]              room,
    input logic [NPORTS*NPORTS-1:0]       rd_start,
    input logic [NPORTS-1:0]              wr_start,
    input logic [NPORTS*IDX_W-1:0]        sel,
    input logic [NPORTS-1:0]              busy,
    input logic [IDX_W-1:0]               ptr
);
    for (genvar j = 0; j < NPORTS; j++) begin : g_o
        logic [NPORTS-1:0] colv;
        for (genvar i = 0; i < NPORTS; i++) begin : g_i
            assign colv[i] = rd_start[i*NPORTS+j];

            a_r5_nonempty_only: assert property (@(posedge clk) disable iff (rst)
                rd_start[i*NPORTS+j] |-> ($past(q_occ[(i*NPORTS+j)*OCC_W +: OCC_W]) != '0));
        end

        a_r2_room_and_idle: assert property (@(posedge clk) disable iff (rst)
            wr_start[j] |-> ($past(room[j]) && !$past(busy[j])));

        a_r10_single_source: assert property (@(posedge clk) disable iff (rst)
            $onehot0(colv));

        a_r6_both_ends: assert property (@(posedge clk) disable iff (rst)
            wr_start[j] == (|colv));

        a_r8_busy_in_pulse: assert property (@(posedge clk) disable iff (rst)
            wr_start[j] |-> busy[j]);

        a_r7_sel_held: assert property (@(posedge clk) disable iff (rst)
            !wr_start[j] |-> $stable(sel[j*IDX_W +: IDX_W]));
    end

    a_r9_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (|wr_start) |-> (int'(ptr) == ((int'($past(ptr)) + 1) % NPORTS)));

    a_r9_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !(|wr_start) |-> $stable(ptr));
endmodule

bind xbar_sched xbar_sched_chk #(.NPORTS(NPORTS), .OCC_W(OCC_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .q_occ    (q_occ_i),
    .room     (ob_room_i),
    .rd_start (rd_start_o),
    .wr_start (wr_start_o),
    .sel      (sel_o),
    .busy     (busy_o),
    .ptr      (ptr_q)
);

// File: tb/xbar_sched_bench.sv
module xbar_sched_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int OW = 4;
    localparam int IW = 2;
    localparam int XF = 8;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [NP*NP*OW-1:0]    q_occ_i = '0;
    logic [NP-1:0]          ob_room_i = '0;
    logic [NP*NP-1:0]       rd_start_o;
    logic [NP-1:0]          wr_start_o;
    logic [NP*IW-1:0]       sel_o;
    logic [NP-1:0]          busy_o;

    xbar_sched u_xbar_sched (
        .clk(clk), .rst(rst), .q_occ_i(q_occ_i), .ob_room_i(ob_room_i),
        .rd_start_o(rd_start_o), .wr_start_o(wr_start_o),
        .sel_o(sel_o), .busy_o(busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // stimulus and reference model state
    int occ [NP][NP];   // [input][output]
    bit room [NP];
    int m_cnt [NP];
    int m_ptr;
    int e_wr [NP];
    int e_rd [NP*NP];
    int e_sel [NP];

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        for (int i = 0; i < NP; i++) begin
            room[i] = 0;
            for (int j = 0; j < NP; j++) occ[i][j] = 0;
        end
    endtask

    // drive inputs and advance the model to the values after the next edge
    task automatic apply();
        int any;
        any = 0;
        for (int i = 0; i < NP; i++) begin
            ob_room_i[i] = room[i];
            for (int j = 0; j < NP; j++)
                q_occ_i[(i*NP+j)*OW +: OW] = OW'(occ[i][j]);
        end
        for (int j = 0; j < NP; j++) begin
            int best, win, hit;
            best = 0; win = 0; hit = 0;
            if (room[j] && m_cnt[j] == 0) begin
                for (int k = 0; k < NP; k++) begin
                    int i;
                    i = (m_ptr + k) % NP;
                    if (occ[i][j] > best) begin
                        best = occ[i][j]; win = i; hit = 1;
                    end
                end
            end
            e_wr[j] = hit;
            for (int i = 0; i < NP; i++) e_rd[i*NP+j] = (hit != 0 && win == i) ? 1 : 0;
            if (hit != 0) begin
                e_sel[j] = win; m_cnt[j] = XF; any = 1;
            end else if (m_cnt[j] > 0) begin
                m_cnt[j] = m_cnt[j] - 1;
            end
        end
        if (any != 0) m_ptr = (m_ptr + 1) % NP;
    endtask

    task automatic step();
        @(negedge clk);
        for (int j = 0; j < NP; j++) begin
            chk("R2 write-start", int'(wr_start_o[j]), e_wr[j]);
            chk("R7 select", int'(sel_o[j*IW +: IW]), e_sel[j]);
            chk("R8 busy", int'(busy_o[j]), (m_cnt[j] != 0) ? 1 : 0);
        end
        for (int q = 0; q < NP*NP; q++)
            chk("R10 read-start", int'(rd_start_o[q]), e_rd[q]);
        apply();
    endtask

    initial begin
        for (int j = 0; j < NP; j++) begin
            m_cnt[j] = 0; e_wr[j] = 0; e_sel[j] = 0;
        end
        for (int q = 0; q < NP*NP; q++) e_rd[q] = 0;
        m_ptr = 0;
        clear_inputs();

        repeat (3) @(negedge clk);
        chk("R1 reset wr", int'(wr_start_o), 0);
        chk("R1 reset rd", int'(rd_start_o), 0);
        chk("R1 reset sel", int'(sel_o), 0);
        chk("R1 reset busy", int'(busy_o), 0);
        rst = 1'b0;
        apply();

        // R2: full queues but no room -> no grant
        for (int i = 0; i < NP; i++) occ[i][0] = 3;
        step();
        step();
        chk("R2 no room", int'(wr_start_o), 0);

        // R4: tie on output 0 with start index 0 -> input 0
        room[0] = 1;
        step();
        clear_inputs();
        step();
        chk("R4 tie sel", int'(sel_o[0 +: IW]), 0);
        chk("R6 wr pulse", int'(wr_start_o), 1);
        chk("R6 rd pulse", int'(rd_start_o), 1);

        // R9: start index now 1; tie on output 1 -> input 1 (queue bit 5)
        for (int i = 0; i < NP; i++) occ[i][1] = 2;
        room[1] = 1;
        step();
        clear_inputs();
        step();
        chk("R9 advanced start", int'(sel_o[1*IW +: IW]), 1);
        chk("R6 rd bit", int'(rd_start_o), 1 << 5);

        // R3: start index 2; counts 1,7,5,2 -> input 1 wins (queue bit 6)
        occ[0][2] = 1; occ[1][2] = 7; occ[2][2] = 5; occ[3][2] = 2;
        room[2] = 1;
        step();
        clear_inputs();
        step();
        chk("R3 largest", int'(sel_o[2*IW +: IW]), 1);
        chk("R3 rd bit", int'(rd_start_o), 1 << 6);

        // R5: empty queues for output 3 -> no grant, start stays 3
        room[3] = 1;
        step();
        step();
        chk("R5 empty", int'(wr_start_o[3]), 0);
        for (int i = 0; i < NP; i++) occ[i][3] = 4;
        step();
        clear_inputs();
        step();
        chk("R9 held start", int'(sel_o[3*IW +: IW]), 3);

        // R8: continuous demand on output 0 -> grants spaced by lock length
        repeat (12) step();
        for (int i = 0; i < NP; i++) occ[i][0] = i + 1;
        room[0] = 1;
        repeat (30) step();
        clear_inputs();
        repeat (10) step();

        // mixed random traffic
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < NP; i++) begin
                room[i] = ($urandom_range(0, 3) != 0);
                for (int j = 0; j < NP; j++)
                    occ[i][j] = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, 15);
            end
            if ((c % 97) < 10)
                for (int i = 0; i < NP; i++)
                    for (int j = 0; j < NP; j++) occ[i][j] = 6;
            step();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule